// File: doc/BRIEF.md
# Interrupt Status Summary Unit

This block keeps the 32-bit status word and the 32-bit interrupt-enable word of a descriptor-driven Ethernet controller and drives a single level-sensitive interrupt line. The transmit and receive engines report what happens to them through one-cycle event pulses. Software reaches the block through a plain register write port. A write to the status address clears bits by writing ones to them. A write to the operating-mode address changes the process-state bits. A write to the enable address replaces the enable word.

Two summary bits are rebuilt from the status word after every update: one for normal conditions and one for abnormal ones. The transmit-unavailable condition is not reported directly. Each report of an unowned transmit descriptor advances an idle counter, and the flag is raised only after more than a set number of such reports in a row. A poll demand preloads the counter so that the next unowned report raises the flag at once. The block has no data stream, so every pin is a plain control or status pin with no handshake.

Top module: `irq_status_unit`

## Requirements
- R1: During and after reset, until the first event or write, `status_o` and `inten_o` read 0 and `irq_o` is low.
- R2: A status write (`wr_addr` 5) clears each status bit that has a 1 in `wr_data` and lies within mask 0x0C01FFFF. Bits outside that mask are unchanged, including the receive-running bit 17.
- R3: Status bit 16 (normal summary) is 1 exactly when any status bit in mask 0x00004845 (bits 0, 2, 6, 11, 14) is 1. This holds after every update.
- R4: Status bit 15 (abnormal summary) is 1 exactly when any status bit in mask 0x0C0037BA is 1. This holds after every update.
- R5: `irq_o` is high exactly while (`status_o` AND `inten_o` AND 0x0C01FFFF) is nonzero. It follows the registered words with no further delay.
- R6: In the cycle after their pulse, the events set these status bits: `ev_tx_done` bit 0, `ev_tx_halt` bit 1, `ev_rx_done` bit 6, `ev_rx_nobuf` bit 7, `ev_rx_halt` bit 8.
- R7: Each `tx_unowned` pulse increments an idle count that starts at 0. A pulse that finds the count above 10 sets status bit 2 (transmit unavailable) and returns the count to 0. The 12th pulse after reset therefore raises bit 2.
- R8: A `tx_poll` pulse, or an operating-mode write (`wr_addr` 6) with bit 3 set, loads the idle count with 11. The next `tx_unowned` pulse then sets bit 2.
- R9: An operating-mode write with bit 13 (transmit start) at 0 sets status bit 1. The same write copies its bit 1 (receive start) into status bit 17, so writing 0 there clears the receive-running indication.
- R10: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A write to address 7 loads `inten_o`. Writes to any address other than 5, 6 or 7 change neither `status_o` nor `inten_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_done | input | 1 | Transmit interrupt event pulse |
| ev_tx_halt | input | 1 | Transmit process stopped event pulse |
| ev_rx_done | input | 1 | Receive interrupt event pulse |
| ev_rx_nobuf | input | 1 | Receive buffer unavailable event pulse |
| ev_rx_halt | input | 1 | Receive process stopped event pulse |
| tx_unowned | input | 1 | Transmit engine met a descriptor it does not own |
| tx_poll | input | 1 | Transmit poll-demand strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write address (5 status, 6 mode, 7 enable) |
| wr_data | input | 32 | Register write data |
| status_o | output | 32 | Status word, including the summary bits |
| inten_o | output | 32 | Interrupt-enable word |
| irq_o | output | 1 | Level interrupt request |

## Verification
The status word, its two summary bits and the enable word all change one clock after the edge that samples an event pulse or a write. The interrupt line follows the same edge with no extra register. The idle counter adds no latency: the pulse that crosses the limit sets bit 2 in the very next cycle. The bench applies stimulus on the falling edge and compares every output with its behavioural model on the following falling edge. Its directed checks read the outputs exactly one full cycle after each stimulus.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned STW = 32;

  // status bit positions
  localparam int unsigned B_TXDONE = 0;
  localparam int unsigned B_TXHALT = 1;
  localparam int unsigned B_TXUNAV = 2;
  localparam int unsigned B_RXDONE = 6;
  localparam int unsigned B_RXNOBUF = 7;
  localparam int unsigned B_RXHALT = 8;
  localparam int unsigned B_ABN = 15;
  localparam int unsigned B_NRM = 16;
  localparam int unsigned B_RXRUN = 17;

  // operating-mode fields decoded on write
  localparam int unsigned M_RXSTART = 1;
  localparam int unsigned M_POLL = 3;
  localparam int unsigned M_TXSTART = 13;

  localparam logic [STW-1:0] CLR_MASK = 32'h0C01_FFFF;
  localparam logic [STW-1:0] NRM_MASK = 32'h0000_4845;
  localparam logic [STW-1:0] ABN_MASK = 32'h0C00_37BA;

  localparam int unsigned A_STATUS = 5;
  localparam int unsigned A_MODE = 6;
  localparam int unsigned A_INTEN = 7;

  typedef struct packed {
    logic tx_done;
    logic tx_halt;
    logic tx_unav;
    logic rx_done;
    logic rx_nobuf;
    logic rx_halt;
  } isu_evt_t;

  function automatic logic [STW-1:0] evt_bits(isu_evt_t e);
    logic [STW-1:0] v;
    v = '0;
    v[B_TXDONE] = e.tx_done;
    v[B_TXHALT] = e.tx_halt;
    v[B_TXUNAV] = e.tx_unav;
    v[B_RXDONE] = e.rx_done;
    v[B_RXNOBUF] = e.rx_nobuf;
    v[B_RXHALT] = e.rx_halt;
    return v;
  endfunction
endpackage

// File: rtl/isu_idle_ctr.sv
module isu_idle_ctr #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic preload,
  input  logic unowned,
  output logic unav_evt
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LOADV = CW'(LIMIT + 1);
  localparam logic [CW-1:0] LIMV = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign unav_evt = unowned && !preload && (cnt_q > LIMV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (preload) begin
      cnt_q <= LOADV;
    end else if (unowned) begin
      if (cnt_q > LIMV) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/isu_status_core.sv
module isu_status_core
  import isu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  isu_evt_t       evt,
  input  logic           clr_we,
  input  logic [STW-1:0] clr_data,
  input  logic           mode_we,
  input  logic           mode_tx_start,
  input  logic           mode_rx_start,
  output logic [STW-1:0] status_q
);
  logic [STW-1:0] nxt;

  always_comb begin
    nxt = status_q;
    if (clr_we) nxt = nxt & ~(clr_data & CLR_MASK);
    if (mode_we) begin
      if (!mode_tx_start) nxt[B_TXHALT] = 1'b1;
      nxt[B_RXRUN] = mode_rx_start;
    end
    // events applied last so they win over a same-cycle clear
    nxt = nxt | evt_bits(evt);
    nxt[B_ABN] = |(nxt & ABN_MASK);
    nxt[B_NRM] = |(nxt & NRM_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else status_q <= nxt;
  end
endmodule

// File: rtl/isu_irq_gate.sv
module isu_irq_gate
  import isu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_we,
  input  logic [STW-1:0] en_data,
  input  logic [STW-1:0] status,
  output logic [STW-1:0] en_q,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (en_we) en_q <= en_data;
  end

  assign irq = |(status & en_q & CLR_MASK);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IDLE_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_done,
  input  logic              ev_tx_halt,
  input  logic              ev_rx_done,
  input  logic              ev_rx_nobuf,
  input  logic              ev_rx_halt,
  input  logic              tx_unowned,
  input  logic              tx_poll,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STW-1:0]    wr_data,
  output logic [STW-1:0]    status_o,
  output logic [STW-1:0]    inten_o,
  output logic              irq_o
);
  logic     we_status, we_mode, we_en, preload, unav_evt;
  isu_evt_t evt;

  assign we_status = wr_en && (wr_addr == ADDR_W'(A_STATUS));
  assign we_mode = wr_en && (wr_addr == ADDR_W'(A_MODE));
  assign we_en = wr_en && (wr_addr == ADDR_W'(A_INTEN));
  assign preload = tx_poll || (we_mode && wr_data[M_POLL]);

  isu_idle_ctr #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .preload (preload),
    .unowned (tx_unowned),
    .unav_evt(unav_evt)
  );

  always_comb begin
    evt.tx_done = ev_tx_done;
    evt.tx_halt = ev_tx_halt;
    evt.tx_unav = unav_evt;
    evt.rx_done = ev_rx_done;
    evt.rx_nobuf = ev_rx_nobuf;
    evt.rx_halt = ev_rx_halt;
  end

  isu_status_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt          (evt),
    .clr_we       (we_status),
    .clr_data     (wr_data),
    .mode_we      (we_mode),
    .mode_tx_start(wr_data[M_TXSTART]),
    .mode_rx_start(wr_data[M_RXSTART]),
    .status_q     (status_o)
  );

  isu_irq_gate u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (we_en),
    .en_data(wr_data),
    .status (status_o),
    .en_q   (inten_o),
    .irq    (irq_o)
  );
endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_tx_done,
  input logic              ev_rx_done,
  input logic              tx_unowned,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       status_o,
  input logic [31:0]       inten_o,
  input logic              irq_o
);
  logic st_wr;
  assign st_wr = wr_en && (wr_addr == ADDR_W'(5));

  // R3
  nrm_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[16] == |(status_o & 32'h0000_4845));

  // R4
  abn_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15] == |(status_o & 32'h0C00_37BA));

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_data[0] && !ev_tx_done) |=> !status_o[0]);

  // R2
  outside_mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> $stable(status_o[17]));

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> status_o[6]);

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (inten_o != 32'h0));

  // R7
  unav_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[2]) |-> $past(tx_unowned));
endmodule

bind irq_status_unit isu_checker #(.ADDR_W(ADDR_W)) u_isu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_tx_done(ev_tx_done),
  .ev_rx_done(ev_rx_done),
  .tx_unowned(tx_unowned),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .status_o  (status_o),
  .inten_o   (inten_o),
  .irq_o     (irq_o)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ev = '0; // {poll, unowned, rx_halt, rx_nobuf, rx_done, tx_halt, tx_done}
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_o, inten_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_status_unit dut (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_done(ev[0]), .ev_tx_halt(ev[1]), .ev_rx_done(ev[2]),
    .ev_rx_nobuf(ev[3]), .ev_rx_halt(ev[4]), .tx_unowned(ev[5]),
    .tx_poll(ev[6]), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status_o(status_o), .inten_o(inten_o), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [31:0] m_st = '0, m_en = '0;
  int m_idle = 0;

  always @(posedge clk) begin
    logic [31:0] s;
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_idle = 0;
    end else begin
      s = m_st;
      if (wr_en && wr_addr == 3'd5) s = s & ~(wr_data & 32'h0C01FFFF);
      if (wr_en && wr_addr == 3'd6) begin
        if (wr_data[13] == 1'b0) s[1] = 1'b1;
        s[17] = wr_data[1];
      end
      if (wr_en && wr_addr == 3'd7) m_en = wr_data;
      if (ev[0]) s[0] = 1'b1;
      if (ev[1]) s[1] = 1'b1;
      if (ev[2]) s[6] = 1'b1;
      if (ev[3]) s[7] = 1'b1;
      if (ev[4]) s[8] = 1'b1;
      if (ev[6] || (wr_en && wr_addr == 3'd6 && wr_data[3])) m_idle = 11;
      else if (ev[5]) begin
        if (m_idle > 10) begin s[2] = 1'b1; m_idle = 0; end
        else m_idle = m_idle + 1;
      end
      s[15] = (s & 32'h0C0037BA) != 0;
      s[16] = (s & 32'h00004845) != 0;
      m_st = s;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 R2 model status", status_o, m_st);
      check("R11 model enable", inten_o, m_en);
      check("R5 model irq", {31'b0, irq_o}, {31'b0, (m_st & m_en & 32'h0C01FFFF) != 0});
    end
  end

  task automatic drive(logic [6:0] e, logic we, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    ev = e; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    ev = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status", status_o, 32'h0);
    check("R1 enable", inten_o, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;

    drive(7'h01, 0, 0, 0);
    check("R6 R3 tx_done", status_o, 32'h00010001);
    check("R5 masked irq", {31'b0, irq_o}, 32'h0);
    drive(7'h00, 1, 3'd7, 32'h1);
    check("R11 enable write", inten_o, 32'h1);
    check("R5 irq high", {31'b0, irq_o}, 32'h1);
    drive(7'h00, 1, 3'd5, 32'h1);
    check("R2 w1c", status_o, 32'h0);
    check("R5 irq low", {31'b0, irq_o}, 32'h0);
    drive(7'h10, 0, 0, 0);
    check("R4 rx_halt", status_o, 32'h00008100);
    drive(7'h00, 1, 3'd6, 32'h00002002);
    check("R9 rx running", status_o, 32'h00028100);
    drive(7'h00, 1, 3'd5, 32'hFFFFFFFF);
    check("R2 outside mask", status_o, 32'h00020000);
    drive(7'h00, 1, 3'd6, 32'h0);
    check("R9 tx stop", status_o, 32'h00008002);
    drive(7'h0C, 0, 0, 0);
    check("R6 rx events", status_o, 32'h000180C2);
    check("R5 unmatched bits", {31'b0, irq_o}, 32'h0);
    drive(7'h00, 1, 3'd5, 32'hFFFFFFFF);

    for (int i = 0; i < 11; i++) drive(7'h20, 0, 0, 0);
    check("R7 below limit", status_o, 32'h0);
    drive(7'h20, 0, 0, 0);
    check("R7 twelfth unowned", status_o, 32'h00010004);

    drive(7'h00, 1, 3'd5, 32'h4);
    drive(7'h40, 0, 0, 0);
    check("R8 poll alone", status_o, 32'h0);
    drive(7'h20, 0, 0, 0);
    check("R8 poll then unowned", status_o, 32'h00010004);

    drive(7'h00, 1, 3'd5, 32'h4);
    drive(7'h00, 1, 3'd6, 32'h0000200A);
    check("R8 mode poll", status_o, 32'h00020000);
    drive(7'h20, 0, 0, 0);
    check("R8 mode poll unowned", status_o, 32'h00030004);

    drive(7'h04, 1, 3'd5, 32'hFFFFFFFF);
    check("R10 event beats clear", status_o, 32'h00030040);
    drive(7'h00, 1, 3'd3, 32'hFFFFFFFF);
    check("R11 other address status", status_o, 32'h00030040);
    check("R11 other address enable", inten_o, 32'h1);
    drive(7'h00, 1, 3'd7, 32'h40);
    check("R5 irq on rx_done", {31'b0, irq_o}, 32'h1);
    drive(7'h00, 1, 3'd5, 32'h40);
    check("R5 irq drops", {31'b0, irq_o}, 32'h0);
    check("R3 summary drops", status_o, 32'h00020000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule